// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block combines three independent reset causes into a single active-high system reset and keeps a record of the cause, so that software can read it once the reset has finished. The three causes are an external active-low reset pin, an interrupt that wakes the chip from deep standby, and an overflow pulse from the watchdog counter.

Each cause has its own rule for asserting and releasing the reset. The pin passes through a two-flop synchronizer and must stay low for a minimum number of clock cycles before it counts as a reset. Shorter glitches are discarded. A pin reset stays asserted for as long as the pin is held low. A standby wake asserts the reset and requests oscillator start in the same cycle. It then holds the reset for a delay that software can program. A watchdog overflow produces a reset only while the watchdog-reset enable is 1, and it releases by itself after a fixed hold interval.

Three status bits record the causes, and software clears each bit by writing 1 to it. When more than one cause is active, the system reset stays asserted until every active cause has released.

Top module: `sys_reset_ctrl`

## Requirements
- R1: A low pulse on `rst_pin_n` that lasts fewer than MIN_LOW (default 20) clock cycles never asserts `sys_rst` and never sets the pin status bit.
- R2: When `rst_pin_n` is held low for at least MIN_LOW cycles, `sys_rst` asserts and stays high while the pin is low. It drops within 3 cycles after the pin returns high, provided no other cause is active.
- R3: A one-cycle `wake_evt` pulse raises `sys_rst` and `osc_start` together in the cycle after the event. `osc_start` is high for exactly one cycle.
- R4: A standby-wake reset keeps `sys_rst` high for `wake_dly`+1 cycles, counting from the cycle in which it rose.
- R5: While `wdt_rst_en` is 0, a `wdt_ovf` pulse has no effect: `sys_rst` stays low and the watchdog status bit stays 0.
- R6: While `wdt_rst_en` is 1, a `wdt_ovf` pulse raises `sys_rst` in the next cycle and holds it for exactly WDT_HOLD (default 512) cycles.
- R7: `rst_src` encodes the causes as follows: bit 0 is the pin, bit 1 is the standby wake and bit 2 is the watchdog. A pin reset sets bit 0 and clears bits 1 and 2. A wake or watchdog reset sets only its own bit and leaves the other bits unchanged. A wake or watchdog bit is visible in the same cycle that `sys_rst` rises.
- R8: While `clr_we` is 1, every bit of `rst_src` whose `clr_mask` bit is 1 is cleared at the next edge. If a set of the same bit happens in that cycle, the set wins.
- R9: When causes overlap, `sys_rst` stays high until the last active cause releases. A watchdog reset that overlaps a shorter wake reset still lasts WDT_HOLD cycles, and both status bits are set.
- R10: While `rst_n` is low, and directly after it is released, `sys_rst`, `osc_start` and `rst_src` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low initialization of the controller |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous to clk |
| wake_evt | input | 1 | Deep-standby wake interrupt, one-cycle pulse |
| wake_dly | input | DLY_W | Wake reset length minus one, in cycles |
| wdt_ovf | input | 1 | Watchdog overflow, one-cycle pulse |
| wdt_rst_en | input | 1 | Watchdog overflow may cause a reset when 1 |
| clr_we | input | 1 | Status clear strobe |
| clr_mask | input | 3 | Status bits to clear when the strobe is 1 (1 means clear) |
| sys_rst | output | 1 | Internal system reset, active high |
| osc_start | output | 1 | Oscillator start request, one-cycle pulse |
| rst_src | output | 3 | Reset cause status: bit 0 pin, bit 1 wake, bit 2 watchdog |

## Verification
The bench sends pin pulses of random length on both sides of the qualification threshold. A counter with an off-by-one error would either let a 19-cycle glitch through or reject a 20-cycle reset. It measures the exact length of the wake and watchdog resets, which would expose a timer that releases one cycle early or late. It also fires an overflow while the enable is 0, which catches a design that ignores the enable.

Further directed cases cover:
- a clear strobe that arrives in the same cycle as a new watchdog set, which a design that lets the clear win would lose;
- a wake reset nested inside a watchdog reset, which would cut `sys_rst` short if the design released on the first cause to end;
- a pin reset after both other bits are set, which must leave only the pin bit.

// File: rtl/sys_reset_pkg.sv
// Package: shared flag positions and widths for the reset controller.
// Assumes: the three status bits are read by software at these fixed positions.
package sys_reset_pkg;
    localparam int unsigned NUM_SRC  = 3;
    localparam int unsigned FLAG_PIN = 0;
    localparam int unsigned FLAG_WAKE = 1;
    localparam int unsigned FLAG_WDT = 2;
    typedef logic [NUM_SRC-1:0] src_flags_t;
endpackage

// File: rtl/rst_pin_qual.sv
// Module: rst_pin_qual
// Synchronizes the asynchronous active-low pin with two flops and counts
// consecutive low cycles. The output is high once the count reaches MIN_LOW,
// and stays high while the pin remains low.
// Assumes: the pin idles high and rst_n is synchronous to clk.
module rst_pin_qual #(
    parameter int unsigned MIN_LOW = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw_n,
    output logic qual_o
);
    localparam int unsigned CW = $clog2(MIN_LOW + 1);

    logic          sync1_q;
    logic          sync2_q;
    logic [CW-1:0] low_cnt_q;

    // Two-flop synchronizer followed by a saturating low-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q   <= 1'b1;
            sync2_q   <= 1'b1;
            low_cnt_q <= '0;
        end else begin
            sync1_q <= pin_raw_n;
            sync2_q <= sync1_q;
            if (sync2_q)
                low_cnt_q <= '0;
            else if (low_cnt_q != CW'(MIN_LOW))
                low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    // The pin counts as a reset only after the full run of low cycles.
    always_comb qual_o = (low_cnt_q == CW'(MIN_LOW));
endmodule

// File: rtl/rst_hold_timer.sv
// Module: rst_hold_timer
// Holds active_o high for len_i+1 cycles after a start pulse. A new start
// while the timer is running reloads the length.
// Assumes: len_i is sampled only in the cycle where start_i is high.
module rst_hold_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] len_i,
    output logic         active_o
);
    logic [W-1:0] cnt_q;
    logic         act_q;

    // Load on start, count down while active, release after reaching zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            cnt_q <= '0;
        end else if (start_i) begin
            act_q <= 1'b1;
            cnt_q <= len_i;
        end else if (act_q) begin
            if (cnt_q == '0)
                act_q <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // Expose the hold state.
    always_comb active_o = act_q;
endmodule

// File: rtl/rst_src_flags.sv
// Module: rst_src_flags
// Reset-cause status bits with write-1-to-clear. A pin cause replaces the
// whole status with only the pin bit set. Wake and watchdog causes OR in
// their own bits. A set always wins over a clear in the same cycle.
// Assumes: set inputs are already qualified by the caller.
module rst_src_flags
    import sys_reset_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_pin_i,
    input  logic       set_wake_i,
    input  logic       set_wdt_i,
    input  logic       clr_we_i,
    input  src_flags_t clr_mask_i,
    output src_flags_t flags_o
);
    src_flags_t flags_q;
    src_flags_t flags_d;

    // Next-state: apply the clear first, then the sets so that they dominate.
    always_comb begin
        flags_d = flags_q & ~(clr_we_i ? clr_mask_i : '0);
        if (set_pin_i) begin
            flags_d           = '0;
            flags_d[FLAG_PIN] = 1'b1;
        end else begin
            if (set_wake_i) flags_d[FLAG_WAKE] = 1'b1;
            if (set_wdt_i)  flags_d[FLAG_WDT]  = 1'b1;
        end
    end

    // Status register.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    // Expose the status bits.
    always_comb flags_o = flags_q;
endmodule

// File: rtl/sys_reset_ctrl.sv
// Module: sys_reset_ctrl (top)
// Merges the pin, standby-wake and watchdog reset causes into one system
// reset, requests oscillator start on wake, and records the causes.
// The system reset is the OR of the three per-cause hold states, so it stays
// asserted until the last active cause releases.
// Assumes: wake_evt and wdt_ovf are one-cycle pulses synchronous to clk.
module sys_reset_ctrl
    import sys_reset_pkg::*;
#(
    parameter int unsigned MIN_LOW  = 20,
    parameter int unsigned WDT_HOLD = 512,
    parameter int unsigned DLY_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_pin_n,
    input  logic             wake_evt,
    input  logic [DLY_W-1:0] wake_dly,
    input  logic             wdt_ovf,
    input  logic             wdt_rst_en,
    input  logic             clr_we,
    input  logic [2:0]       clr_mask,
    output logic             sys_rst,
    output logic             osc_start,
    output logic [2:0]       rst_src
);
    localparam int unsigned HOLD_W = $clog2(WDT_HOLD);

    logic pin_act;
    logic wake_act;
    logic wdt_act;
    logic wdt_fire;
    logic osc_q;
    src_flags_t flags;

    // Overflow qualified by the enable; ignored entirely otherwise.
    always_comb wdt_fire = wdt_ovf & wdt_rst_en;

    rst_pin_qual #(.MIN_LOW(MIN_LOW)) u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_raw_n (rst_pin_n),
        .qual_o    (pin_act)
    );

    rst_hold_timer #(.W(DLY_W)) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (wake_evt),
        .len_i    (wake_dly),
        .active_o (wake_act)
    );

    rst_hold_timer #(.W(HOLD_W)) u_wdt (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (wdt_fire),
        .len_i    (HOLD_W'(WDT_HOLD - 1)),
        .active_o (wdt_act)
    );

    rst_src_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_pin_i  (pin_act),
        .set_wake_i (wake_evt),
        .set_wdt_i  (wdt_fire),
        .clr_we_i   (clr_we),
        .clr_mask_i (clr_mask),
        .flags_o    (flags)
    );

    // One-cycle oscillator start request aligned with the wake reset rising.
    always_ff @(posedge clk) begin
        if (!rst_n) osc_q <= 1'b0;
        else        osc_q <= wake_evt;
    end

    // Output drive.
    always_comb begin
        sys_rst   = pin_act | wake_act | wdt_act;
        osc_start = osc_q;
        rst_src   = flags;
    end
endmodule

// File: rtl/sys_reset_ctrl_chk.sv
// Module: sys_reset_ctrl_chk
// Property checker for sys_reset_ctrl, attached by bind below.
// Assumes: it is bound into the top so that pin_act is visible.
module sys_reset_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wake_evt,
    input logic       wdt_ovf,
    input logic       wdt_rst_en,
    input logic       pin_act,
    input logic       sys_rst,
    input logic       osc_start,
    input logic [2:0] rst_src
);
    // R3: a wake event gives a reset and an oscillator request in the next cycle.
    a_r3_wake_osc: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wake_evt)) |-> (sys_rst && osc_start));

    // R3: the oscillator request never appears outside a reset.
    a_r3_osc_in_rst: assert property (@(posedge clk) disable iff (!rst_n)
        osc_start |-> sys_rst);

    // R5: the watchdog bit can rise only after an enabled overflow.
    a_r5_wdt_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(rst_src[2])) |-> $past(wdt_ovf && wdt_rst_en));

    // R6: an enabled overflow raises the reset in the next cycle.
    a_r6_wdt_rst: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wdt_ovf && wdt_rst_en)) |-> sys_rst);

    // R7: a new pin bit leaves the other two bits clear.
    a_r7_pin_excl: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(rst_src[0])) |-> (rst_src[2:1] == 2'b00));

    // R8: a watchdog set survives a same-cycle clear unless a pin cause replaces it.
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wdt_ovf && wdt_rst_en && !pin_act)) |-> rst_src[2]);

    // R2: a qualified pin keeps the system reset asserted.
    a_r2_pin_holds: assert property (@(posedge clk) disable iff (!rst_n)
        pin_act |-> sys_rst);
endmodule

bind sys_reset_ctrl sys_reset_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wake_evt   (wake_evt),
    .wdt_ovf    (wdt_ovf),
    .wdt_rst_en (wdt_rst_en),
    .pin_act    (pin_act),
    .sys_rst    (sys_rst),
    .osc_start  (osc_start),
    .rst_src    (rst_src)
);

// File: tb/sim_sys_reset_ctrl.sv
module sim_sys_reset_ctrl;
    localparam int MIN_LOW  = 20;
    localparam int WDT_HOLD = 512;
    localparam int DLY_W    = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rst_pin_n = 1'b1;
    logic             wake_evt = 1'b0;
    logic [DLY_W-1:0] wake_dly = '0;
    logic             wdt_ovf = 1'b0;
    logic             wdt_rst_en = 1'b0;
    logic             clr_we = 1'b0;
    logic [2:0]       clr_mask = '0;
    logic             sys_rst;
    logic             osc_start;
    logic [2:0]       rst_src;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sys_reset_ctrl #(.MIN_LOW(MIN_LOW), .WDT_HOLD(WDT_HOLD), .DLY_W(DLY_W)) u0 (
        .clk(clk), .rst_n(rst_n), .rst_pin_n(rst_pin_n), .wake_evt(wake_evt),
        .wake_dly(wake_dly), .wdt_ovf(wdt_ovf), .wdt_rst_en(wdt_rst_en),
        .clr_we(clr_we), .clr_mask(clr_mask), .sys_rst(sys_rst),
        .osc_start(osc_start), .rst_src(rst_src)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected pin outcome: qualified only when long enough.
    function automatic bit exp_pin_rst(input int len);
        return len >= MIN_LOW;
    endfunction

    // Expected status after a pin reset, then a flag OR for the other causes.
    function automatic logic [2:0] exp_after(input logic [2:0] cur, input bit pin,
                                             input bit wake, input bit wdt);
        if (pin) return 3'b001;
        return cur | {wdt, wake, 1'b0};
    endfunction

    // Pin pulse of len cycles; reports whether reset was seen and any early drop.
    task automatic pin_pulse(input int len, output bit seen, output bit dropped);
        seen = 0; dropped = 0;
        @(negedge clk) rst_pin_n = 1'b0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (sys_rst) seen = 1;
            else if (seen) dropped = 1;
        end
        rst_pin_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (sys_rst) seen = 1;
        end
    endtask

    // Count cycles of sys_rst high, starting at the current negedge sample.
    task automatic count_high(output int n);
        n = 0;
        while (sys_rst && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog timeout actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit seen, dropped;
        int n, d;
        logic [2:0] expf;
        void'($urandom(32'd7151));

        repeat (3) @(negedge clk);
        chk(sys_rst == 0 && osc_start == 0 && rst_src == 0, "R10 in reset", int'(rst_src), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sys_rst == 0 && osc_start == 0 && rst_src == 0, "R10 after reset", int'(sys_rst), 0);

        // R1: short glitches, random lengths below the threshold plus the 19-cycle edge
        for (int k = 0; k < 6; k++) begin
            n = (k == 0) ? MIN_LOW - 1 : 1 + int'($urandom_range(MIN_LOW - 2));
            pin_pulse(n, seen, dropped);
            chk(seen == exp_pin_rst(n), "R1 short pulse filtered", int'(seen), 0);
            chk(rst_src[0] == 1'b0, "R1 no pin flag", int'(rst_src), 0);
        end

        // R2: long pulses at and above the threshold
        for (int k = 0; k < 4; k++) begin
            n = (k == 0) ? MIN_LOW : MIN_LOW + int'($urandom_range(30));
            pin_pulse(n + 2, seen, dropped);
            chk(seen == exp_pin_rst(n), "R2 long pulse resets", int'(seen), 1);
            chk(!dropped, "R2 held while low", int'(dropped), 0);
            chk(sys_rst == 0, "R2 released after pin high", int'(sys_rst), 0);
            chk(rst_src == 3'b001, "R7 pin flag", int'(rst_src), 1);
        end

        // R8: clear the pin bit
        @(negedge clk) begin clr_we = 1; clr_mask = 3'b001; end
        @(negedge clk) begin clr_we = 0; clr_mask = 0; end
        chk(rst_src == 3'b000, "R8 clear pin bit", int'(rst_src), 0);

        // R5: overflow with the enable low is ignored
        @(negedge clk) begin wdt_ovf = 1; wdt_rst_en = 0; end
        @(negedge clk) wdt_ovf = 0;
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            if (sys_rst) seen = 1;
            @(negedge clk);
        end
        chk(!seen, "R5 disabled overflow no reset", int'(seen), 0);
        chk(rst_src == 3'b000, "R5 disabled overflow no flag", int'(rst_src), 0);

        // R3/R4: wake resets with random delays, including 0
        expf = rst_src;
        for (int k = 0; k < 3; k++) begin
            d = (k == 0) ? 0 : int'($urandom_range(200));
            @(negedge clk) begin wake_evt = 1; wake_dly = DLY_W'(d); end
            @(negedge clk) wake_evt = 0;
            chk(sys_rst && osc_start, "R3 reset and osc together", int'(osc_start), 1);
            expf = exp_after(expf, 0, 1, 0);
            chk(rst_src == expf, "R7 wake flag with reset", int'(rst_src), int'(expf));
            @(negedge clk);
            chk(!osc_start, "R3 osc one cycle", int'(osc_start), 0);
            count_high(n);
            chk(n + 1 == d + 1, "R4 wake length", n + 1, d + 1);
        end

        // R6: enabled watchdog reset length; R7 wake bit kept
        @(negedge clk) begin wdt_ovf = 1; wdt_rst_en = 1; end
        @(negedge clk) wdt_ovf = 0;
        expf = exp_after(expf, 0, 0, 1);
        chk(rst_src == expf && expf == 3'b110, "R7 wdt flag keeps wake", int'(rst_src), int'(expf));
        count_high(n);
        chk(n == WDT_HOLD, "R6 watchdog hold", n, WDT_HOLD);

        // R8: selective clear of the wake bit
        @(negedge clk) begin clr_we = 1; clr_mask = 3'b010; end
        @(negedge clk) begin clr_we = 0; clr_mask = 0; end
        chk(rst_src == 3'b100, "R8 selective clear", int'(rst_src), 4);

        // R8: clear and set of the watchdog bit in the same cycle; the set wins
        @(negedge clk) begin wdt_ovf = 1; clr_we = 1; clr_mask = 3'b100; end
        @(negedge clk) begin wdt_ovf = 0; clr_we = 0; clr_mask = 0; end
        chk(rst_src[2] == 1'b1, "R8 set beats clear", int'(rst_src), 4);
        count_high(n);
        @(negedge clk) begin clr_we = 1; clr_mask = 3'b111; end
        @(negedge clk) begin clr_we = 0; clr_mask = 0; end
        chk(rst_src == 3'b000, "R8 clear all", int'(rst_src), 0);

        // R9: wake nested inside a watchdog reset
        @(negedge clk) wdt_ovf = 1;
        @(negedge clk) wdt_ovf = 0;
        n = 0;
        while (sys_rst && n < 5000) begin
            if (n == 100) begin wake_evt = 1; wake_dly = 8'd20; end
            if (n == 101) wake_evt = 0;
            n++;
            @(negedge clk);
        end
        chk(n == WDT_HOLD, "R9 overlap length", n, WDT_HOLD);
        chk(rst_src == 3'b110, "R9 both flags", int'(rst_src), 6);

        // R7/R9: pin reset replaces the other bits
        pin_pulse(MIN_LOW + 5, seen, dropped);
        chk(seen, "R9 pin after others", int'(seen), 1);
        chk(rst_src == exp_after(3'b110, 1, 0, 0), "R7 pin clears others", int'(rst_src), 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule